// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Keyed Register Access

This block is a memory-mapped watchdog for a processor subsystem. A prescaler slices the bus clock into ticks, and a down-counter runs through two back-to-back stages. When the first stage runs out, an interrupt status bit is raised so software gets a warning. If software still does not service the watchdog, the second stage runs out. This sets a sticky timeout flag and, when enabled, drives a reset request to the system reset controller.

Four registers are keyed: the two stage preloads, the interrupt status and the service register. A write to any of them takes effect only when the two-write key sequence comes just before it, and each key sequence opens exactly one write. The control register is not keyed. Its lock bit keeps the watchdog running until the next block reset, whatever software writes afterwards. Software services the watchdog with a keyed write to the service register, which restarts the countdown from the first-stage preload.

Top module: `wdog2s_top`

## Requirements
- R1: Two writes to offset 0x0C open the key, the first with low byte 0x80 and the second with low byte 0x86. The next write to a keyed offset (0x00, 0x04, 0x08 or 0x0C) is then accepted, and any keyed write after that one is ignored until the key is given again.
- R2: A keyed write without an open key is ignored and leaves the key closed. After 0x80 has been written, any keyed write that is not 0x86 to offset 0x0C (0x80 included) returns the key sequence to its start.
- R3: Once enabled, the counter loads the stage-1 preload P1 (offset 0x00). A tick occurs every 2^PRESCALE_W clocks, and stage 1 ends on the (P1+1)-th tick. At that point bit 0 of offset 0x08 is set and the `irq` output goes high.
- R4: After stage 1, the counter loads the stage-2 preload P2 (offset 0x04) and ends stage 2 on the (P2+1)-th tick. This sets the timeout flag (bit 9 of offset 0x0C). `rst_req` is raised only if the reboot-enable bit is set.
- R5: Once high, `rst_req` stays high until `rst_n` is asserted.
- R6: A keyed write with bit 8 set to offset 0x0C restarts stage 1 from P1 and restarts the prescaler. A pending expiry is put off by the full stage-1 time.
- R7: A keyed write with bit 0 set to offset 0x08 clears the interrupt status. A keyed write with bit 9 set to offset 0x0C clears the timeout flag. Writes to these offsets without the key change nothing.
- R8: The control register at offset 0x10 is written without the key. Its bits are lock (bit 0), enable (bit 1), periodic mode (bit 2) and reboot enable (bit 5), and it reads back these bits.
- R9: While lock is set, a control write cannot clear lock or enable and cannot change periodic mode or reboot enable. It can still set enable.
- R10: While enable is clear, the count at offset 0x14 follows P1, and neither the interrupt status nor `rst_req` is raised.
- R11: In periodic mode, each stage-1 expiry reloads P1 and raises the interrupt status. Stage 2, the timeout flag and `rst_req` are never reached.
- R12: After reset, both preloads hold all ones, the control bits are zero, and `irq`, `rst_req` and the timeout flag are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Byte offset of the read |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| irq | output | 1 | Stage-1 interrupt status level |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The bench builds the block with a 2-bit prescaler and a 12-bit counter. A tick therefore arrives every four clocks, and both stages expire within a few dozen cycles. This lets the bench compare stage-1 and stage-2 expiry times cycle for cycle against (P+1)·4. It can also exercise servicing just before an expiry, periodic mode and the sticky reset request over many stage periods. The 12-bit preload also keeps the all-ones reset value small enough that the disabled hold and the reset value can be read back and checked in a short run.

// File: rtl/wdog2s_pkg.sv
`timescale 1ns/1ps
package wdog2s_pkg;

   typedef enum logic [1:0] {
      KEY_CLOSED = 2'd0,
      KEY_HALF   = 2'd1,
      KEY_OPEN   = 2'd2
   } key_state_e;

   localparam logic [7:0] KEY_BYTE_A = 8'h80;
   localparam logic [7:0] KEY_BYTE_B = 8'h86;

   localparam logic [7:0] OFS_PRE1  = 8'h00;
   localparam logic [7:0] OFS_PRE2  = 8'h04;
   localparam logic [7:0] OFS_STAT  = 8'h08;
   localparam logic [7:0] OFS_SERV  = 8'h0C;
   localparam logic [7:0] OFS_CTRL  = 8'h10;
   localparam logic [7:0] OFS_COUNT = 8'h14;

   localparam int CB_LOCK   = 0;
   localparam int CB_EN     = 1;
   localparam int CB_PERIOD = 2;
   localparam int CB_REBOOT = 5;

   localparam int SB_RESTART = 8;
   localparam int SB_TOFLAG  = 9;

endpackage

// File: rtl/wdog2s_key.sv
`timescale 1ns/1ps
module wdog2s_key #(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        key_byte,
   output logic              grant
);
   import wdog2s_pkg::*;

   key_state_e state_q;
   logic       keyed_wr;
   logic       at_serv;

   assign keyed_wr = wr_en && (wr_addr[ADDR_W-1:4] == '0) && (wr_addr[1:0] == 2'b00);
   assign at_serv  = (wr_addr == OFS_SERV[ADDR_W-1:0]);
   assign grant    = keyed_wr && (state_q == KEY_OPEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= KEY_CLOSED;
      end else if (keyed_wr) begin
         case (state_q)
            KEY_CLOSED: state_q <= (at_serv && key_byte == KEY_BYTE_A) ? KEY_HALF : KEY_CLOSED;
            KEY_HALF:   state_q <= (at_serv && key_byte == KEY_BYTE_B) ? KEY_OPEN : KEY_CLOSED;
            default:    state_q <= KEY_CLOSED;
         endcase
      end
   end
endmodule

// File: rtl/wdog2s_count.sv
`timescale 1ns/1ps
module wdog2s_count #(
   parameter int PRESCALE_W = 15,
   parameter int CNT_W      = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             periodic,
   input  logic             restart,
   input  logic [CNT_W-1:0] pre1,
   input  logic [CNT_W-1:0] pre2,
   output logic [CNT_W-1:0] count,
   output logic             exp1,
   output logic             exp2
);
   logic tick;
   logic stage_q;
   logic at_zero;

   generate
      if (PRESCALE_W == 0) begin : g_nodiv
         assign tick = run && !restart;
      end else begin : g_div
         logic [PRESCALE_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              div_q <= '0;
            else if (!run || restart) div_q <= '0;
            else                      div_q <= div_q + 1'b1;
         end
         assign tick = run && !restart && (&div_q);
      end
   endgenerate

   assign at_zero = (count == '0);
   assign exp1    = tick && at_zero && !stage_q;
   assign exp2    = tick && at_zero && stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '1;
         stage_q <= 1'b0;
      end else if (!run || restart) begin
         count   <= pre1;
         stage_q <= 1'b0;
      end else if (tick) begin
         if (!at_zero) begin
            count <= count - 1'b1;
         end else if (!stage_q && !periodic) begin
            count   <= pre2;
            stage_q <= 1'b1;
         end else begin
            count   <= pre1;
            stage_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/wdog2s_regs.sv
`timescale 1ns/1ps
module wdog2s_regs #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              grant,
   input  logic              exp1,
   input  logic              exp2,
   output logic [CNT_W-1:0]  pre1,
   output logic [CNT_W-1:0]  pre2,
   output logic              lock,
   output logic              en,
   output logic              periodic,
   output logic              reboot,
   output logic              irq_st,
   output logic              toflag,
   output logic              rst_req,
   output logic              restart
);
   import wdog2s_pkg::*;

   logic sel_pre1, sel_pre2, sel_stat, sel_serv, sel_ctrl;
   logic unused_wdata;

   assign sel_pre1 = (wr_addr == OFS_PRE1[ADDR_W-1:0]);
   assign sel_pre2 = (wr_addr == OFS_PRE2[ADDR_W-1:0]);
   assign sel_stat = (wr_addr == OFS_STAT[ADDR_W-1:0]);
   assign sel_serv = (wr_addr == OFS_SERV[ADDR_W-1:0]);
   assign sel_ctrl = (wr_addr == OFS_CTRL[ADDR_W-1:0]);
   assign restart  = grant && sel_serv && wr_data[SB_RESTART];
   assign unused_wdata = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre1     <= '1;
         pre2     <= '1;
         lock     <= 1'b0;
         en       <= 1'b0;
         periodic <= 1'b0;
         reboot   <= 1'b0;
         irq_st   <= 1'b0;
         toflag   <= 1'b0;
         rst_req  <= 1'b0;
      end else begin
         if (grant && sel_pre1) pre1 <= wr_data[CNT_W-1:0];
         if (grant && sel_pre2) pre2 <= wr_data[CNT_W-1:0];
         if (exp1)                                  irq_st <= 1'b1;
         else if (grant && sel_stat && wr_data[0])  irq_st <= 1'b0;
         if (exp2)                                  toflag <= 1'b1;
         else if (grant && sel_serv && wr_data[SB_TOFLAG]) toflag <= 1'b0;
         if (exp2 && reboot) rst_req <= 1'b1;
         if (wr_en && sel_ctrl) begin
            if (lock) begin
               en <= en | wr_data[CB_EN];
            end else begin
               lock     <= wr_data[CB_LOCK];
               en       <= wr_data[CB_EN];
               periodic <= wr_data[CB_PERIOD];
               reboot   <= wr_data[CB_REBOOT];
            end
         end
      end
   end
endmodule

// File: rtl/wdog2s_top.sv
`timescale 1ns/1ps
module wdog2s_top #(
   parameter int PRESCALE_W = 15,
   parameter int CNT_W      = 20,
   parameter int ADDR_W     = 5,
   parameter int DATA_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq,
   output logic              rst_req
);
   import wdog2s_pkg::*;

   initial begin
      assert (ADDR_W >= 5) else $fatal(1, "ADDR_W must reach offset 0x14");
      assert (DATA_W > SB_TOFLAG) else $fatal(1, "DATA_W too narrow for service bits");
      assert (CNT_W >= 2 && CNT_W <= DATA_W) else $fatal(1, "CNT_W out of range");
      assert (PRESCALE_W >= 0 && PRESCALE_W <= 24) else $fatal(1, "PRESCALE_W out of range");
   end

   logic             prot_grant;
   logic [CNT_W-1:0] pre1_q, pre2_q, count_q;
   logic             ctl_lock, ctl_en, ctl_periodic, ctl_reboot;
   logic             irq_st, toflag, restart, exp1, exp2;

   wdog2s_key #(.ADDR_W(ADDR_W)) u_key (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .key_byte(wr_data[7:0]), .grant(prot_grant)
   );

   wdog2s_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .grant(prot_grant), .exp1(exp1), .exp2(exp2),
      .pre1(pre1_q), .pre2(pre2_q), .lock(ctl_lock), .en(ctl_en),
      .periodic(ctl_periodic), .reboot(ctl_reboot), .irq_st(irq_st),
      .toflag(toflag), .rst_req(rst_req), .restart(restart)
   );

   wdog2s_count #(.PRESCALE_W(PRESCALE_W), .CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .run(ctl_en), .periodic(ctl_periodic),
      .restart(restart), .pre1(pre1_q), .pre2(pre2_q), .count(count_q),
      .exp1(exp1), .exp2(exp2)
   );

   assign irq = irq_st;

   always_comb begin
      rd_data = '0;
      if (rd_addr == OFS_PRE1[ADDR_W-1:0])       rd_data = DATA_W'(pre1_q);
      else if (rd_addr == OFS_PRE2[ADDR_W-1:0])  rd_data = DATA_W'(pre2_q);
      else if (rd_addr == OFS_STAT[ADDR_W-1:0])  rd_data[0] = irq_st;
      else if (rd_addr == OFS_SERV[ADDR_W-1:0])  rd_data[SB_TOFLAG] = toflag;
      else if (rd_addr == OFS_CTRL[ADDR_W-1:0]) begin
         rd_data[CB_LOCK]   = ctl_lock;
         rd_data[CB_EN]     = ctl_en;
         rd_data[CB_PERIOD] = ctl_periodic;
         rd_data[CB_REBOOT] = ctl_reboot;
      end
      else if (rd_addr == OFS_COUNT[ADDR_W-1:0]) rd_data = DATA_W'(count_q);
   end
endmodule

// File: rtl/wdog2s_checker.sv
`timescale 1ns/1ps
module wdog2s_checker #(
   parameter int CNT_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             grant,
   input logic [CNT_W-1:0] pre1,
   input logic             lock,
   input logic             en,
   input logic             reboot,
   input logic             irq,
   input logic             rst_req
);
   a_r1_key_single_use: assert property (@(posedge clk) disable iff (!rst_n)
      grant |=> !grant);

   a_r2_preload_guarded: assert property (@(posedge clk) disable iff (!rst_n)
      !grant |=> $stable(pre1));

   a_r4_reset_needs_reboot: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> $past(reboot));

   a_r5_reset_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> rst_req);

   a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> lock);

   a_r9_enable_held: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && en) |=> en);

   a_r10_idle_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !irq) |=> !irq);

   a_r10_idle_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !rst_req) |=> !rst_req);
endmodule

bind wdog2s_top wdog2s_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .grant(prot_grant), .pre1(pre1_q),
   .lock(ctl_lock), .en(ctl_en), .reboot(ctl_reboot),
   .irq(irq), .rst_req(rst_req)
);

// File: tb/test_wdog2s_top.sv
`timescale 1ns/1ps
module test_wdog2s_top;
   localparam int PW = 2;
   localparam int CW = 12;
   localparam int AW = 5;
   localparam int DW = 32;
   localparam int TICK = 1 << PW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          irq, rst_req;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   wdog2s_top #(.PRESCALE_W(PW), .CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) i_wdog2s_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      wr_en = 1'b1; wr_addr = a[AW-1:0]; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      rd_addr = a[AW-1:0];
      #1;
      d = rd_data;
   endtask

   task automatic key_wr(logic [7:0] a, logic [31:0] d);
      wr(8'h0C, 32'h80);
      wr(8'h0C, 32'h86);
      wr(a, d);
   endtask

   task automatic do_reset;
      rst_n = 1'b0; wr_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_irq(output int n);
      n = 1;
      while (!irq && n < 2000) begin @(negedge clk); n++; end
   endtask

   task automatic wait_rst(output int n);
      n = 1;
      while (!rst_req && n < 2000) begin @(negedge clk); n++; end
   endtask

   task automatic t_reset_state;
      logic [31:0] v;
      do_reset();
      check("R12", "irq after reset", irq, 0);
      check("R12", "rst_req after reset", rst_req, 0);
      rd(8'h00, v); check("R12", "stage-1 preload", v, 32'hFFF);
      rd(8'h04, v); check("R12", "stage-2 preload", v, 32'hFFF);
      rd(8'h10, v); check("R12", "control", v, 0);
      rd(8'h0C, v); check("R12", "timeout flag", v, 0);
   endtask

   task automatic t_key;
      logic [31:0] v;
      do_reset();
      wr(8'h00, 32'h111);
      rd(8'h00, v); check("R2", "write without key", v, 32'hFFF);
      key_wr(8'h00, 32'h222);
      wr(8'h00, 32'h333);
      rd(8'h00, v); check("R1", "one write per key", v, 32'h222);
      wr(8'h0C, 32'h80); wr(8'h0C, 32'h85); wr(8'h0C, 32'h86); wr(8'h00, 32'h444);
      rd(8'h00, v); check("R2", "wrong second byte", v, 32'h222);
      wr(8'h0C, 32'h80); wr(8'h00, 32'h555); wr(8'h0C, 32'h86); wr(8'h00, 32'h666);
      rd(8'h00, v); check("R2", "interleaved write cancels", v, 32'h222);
      key_wr(8'h04, 32'h0AB);
      rd(8'h04, v); check("R1", "stage-2 preload keyed write", v, 32'h0AB);
   endtask

   task automatic t_disabled_hold;
      logic [31:0] v;
      do_reset();
      key_wr(8'h00, 32'h123);
      repeat (40) @(negedge clk);
      rd(8'h14, v); check("R10", "count follows preload while disabled", v, 32'h123);
      check("R10", "no irq while disabled", irq, 0);
   endtask

   task automatic t_two_stage;
      logic [31:0] v;
      int n;
      do_reset();
      key_wr(8'h00, 32'd5);
      key_wr(8'h04, 32'd3);
      wr(8'h10, 32'h22);
      wait_irq(n);
      check("R3", "stage-1 expiry cycle", n, TICK*6+1);
      check("R4", "no reset at stage-1 expiry", rst_req, 0);
      wait_rst(n);
      check("R4", "stage-2 expiry cycle", n, TICK*4+1);
      rd(8'h0C, v); check("R4", "timeout flag set", v, 32'h200);
      repeat (60) @(negedge clk);
      check("R5", "reset request held", rst_req, 1);
      do_reset();
      check("R5", "reset request cleared by block reset", rst_req, 0);
   endtask

   task automatic t_no_reboot_and_flag;
      logic [31:0] v;
      do_reset();
      key_wr(8'h00, 32'd1);
      key_wr(8'h04, 32'd1);
      wr(8'h10, 32'h02);
      repeat (60) @(negedge clk);
      check("R4", "no reset when reboot disabled", rst_req, 0);
      rd(8'h0C, v); check("R4", "flag set without reboot", v, 32'h200);
      wr(8'h10, 32'h00);
      wr(8'h0C, 32'h200);
      rd(8'h0C, v); check("R7", "flag kept without key", v, 32'h200);
      key_wr(8'h0C, 32'h200);
      rd(8'h0C, v); check("R7", "flag cleared with key", v, 0);
   endtask

   task automatic t_service;
      int n;
      do_reset();
      key_wr(8'h00, 32'd5);
      wr(8'h10, 32'h02);
      repeat (18) @(negedge clk);
      wr(8'h0C, 32'h80); wr(8'h0C, 32'h86);
      check("R6", "no irq before service", irq, 0);
      wr(8'h0C, 32'h100);
      wait_irq(n);
      check("R6", "expiry restarted by service", n, TICK*6+1);
      wr(8'h08, 32'h1);
      check("R7", "status kept without key", irq, 1);
      key_wr(8'h08, 32'h1);
      check("R7", "status cleared with key", irq, 0);
   endtask

   task automatic t_lock;
      logic [31:0] v;
      do_reset();
      wr(8'h10, 32'h03);
      wr(8'h10, 32'h00);
      rd(8'h10, v); check("R9", "lock keeps enable", v, 32'h03);
      wr(8'h10, 32'h24);
      rd(8'h10, v); check("R9", "lock freezes mode bits", v, 32'h03);
      do_reset();
      wr(8'h10, 32'h01);
      wr(8'h10, 32'h02);
      rd(8'h10, v); check("R9", "locked enable may be set", v, 32'h03);
      do_reset();
      wr(8'h10, 32'h26);
      rd(8'h10, v); check("R8", "control read back", v, 32'h26);
   endtask

   task automatic t_periodic;
      logic [31:0] v;
      int n;
      do_reset();
      key_wr(8'h00, 32'd2);
      key_wr(8'h04, 32'd1);
      wr(8'h10, 32'h26);
      wait_irq(n);
      check("R11", "periodic first expiry", n, TICK*3+1);
      repeat (100) @(negedge clk);
      check("R11", "no reset in periodic mode", rst_req, 0);
      rd(8'h0C, v); check("R11", "no flag in periodic mode", v, 0);
      key_wr(8'h08, 32'h1);
      wait_irq(n);
      check("R11", "periodic expiry repeats", irq, 1);
   endtask

   initial begin
      t_reset_state();
      t_key();
      t_disabled_hold();
      t_two_stage();
      t_no_reboot_and_flag();
      t_service();
      t_lock();
      t_periodic();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1..R12 run: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule